// File: doc/BRIEF.md
# Device Startup Sequencer

This block runs the startup phase that comes after a device has finished loading its configuration. Once a start request arrives, it steps a phase counter through phases 0 to 7, one phase per startup-clock cycle. Four events are tied to programmable phases:
- the open-drain DONE line stops being pulled low;
- the global output-disable (GTS) is lifted, so user I/O may drive;
- the global write enable (GWE) is raised, so user storage may change state;
- end of startup (EOS) is flagged.

After DONE has been released, the counter does not move past the next phase until the sampled DONE line reads high. Other devices on the same board can therefore hold the line low to keep their startups in step. An optional pipeline adds cycles before the line is sampled, for slowly rising DONE nets. Two option bits can hold the DONE, GTS and GWE events back until a clock-lock input and an impedance-match input are true. A status word reports the event states, the raw inputs and the current phase.

Top module: `startup_seq`

## Requirements
- R1: After reset, gts is 1, gwe is 0, eos is 0, done_oe is 1 with done_out 0 (line pulled low), and the counter is idle until start is seen high.
- R2: start is sampled only while idle. The counter then starts at phase 0 and processes phase p on the (p+1)th rising edge after the edge that sampled start, unless a stall holds it. After phase 7 is processed the block stays finished.
- R3: Each event takes effect in the cycle its own 3-bit phase input (ph_done, ph_gts, ph_gwe, ph_eos) is processed. Several events may share a phase. The usual setting is DONE 4, GTS 5, GWE 6, EOS 7.
- R4: Releasing DONE sets done_out to 1 and, when opt_drive_done is 0, drops done_oe to 0 so the line floats. status bit 0 shows the release whatever the line level is.
- R5: Once DONE has been released, the counter and all later events hold while the sampled DONE line is low. DONE is sampled through one register, so with opt_done_pipe at 0 the held phase is processed on the second edge after the line goes high.
- R6: With opt_done_pipe at 1, PIPE_DEPTH (default 2) further registers sit in the sampling path. The held phase is then processed on the (PIPE_DEPTH+2)th edge after the line goes high.
- R7: With opt_wait_lock at 1, a phase that carries a DONE, GTS or GWE event holds while clk_locked is 0. It is processed on the first edge at which clk_locked is 1.
- R8: With opt_wait_match at 1, a phase that carries a DONE, GTS or GWE event holds while imp_matched is 0. The condition is checked in the same way as for R7.
- R9: With opt_drive_done at 1, done_oe stays 1 after release, so the line is actively driven to the done_out value of 1.
- R10: eos stays 1 once set, and start or the DONE line level cannot change any output after the sequence has finished.
- R11: The status word is {phase[2:0], imp_matched, clk_locked, eos, gwe, gts, sampled DONE, release}, with release at bit 0 and the phase at bits 9:7. The two input bits and the sampled DONE bit follow their inputs one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Startup clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, sampled while idle |
| done_pin_in | input | 1 | Level read back from the DONE line |
| clk_locked | input | 1 | All clock generators locked |
| imp_matched | input | 1 | Impedance calibration matched |
| opt_wait_lock | input | 1 | Hold gated events until clk_locked |
| opt_wait_match | input | 1 | Hold gated events until imp_matched |
| opt_drive_done | input | 1 | Drive DONE high instead of floating it |
| opt_done_pipe | input | 1 | Add pipeline stages before DONE sampling |
| ph_done | input | 3 | Phase of the DONE release |
| ph_gts | input | 3 | Phase at which GTS is lifted |
| ph_gwe | input | 3 | Phase at which GWE is raised |
| ph_eos | input | 3 | Phase at which EOS is set |
| done_oe | output | 1 | DONE driver enable |
| done_out | output | 1 | DONE driven value |
| gts | output | 1 | Global output-disable, active high |
| gwe | output | 1 | Global write enable |
| eos | output | 1 | End of startup, sticky |
| status | output | 10 | Status word |

## Verification
With no stall, each event is due on the (phase+1)th edge after the start edge. The bench counts edges from that point and records the first edge at which each output changes, for several phase settings. Released stalls resolve 2 edges after the DONE line rises, PIPE_DEPTH+2 edges with the pipeline option, and 1 edge after a wait input rises. For each of these, the bench samples at a falling edge both one edge before the due point, where the output must be unchanged, and at the due point itself. Status input bits are checked one edge after the inputs change.

// File: rtl/startup_seq.sv
module startup_seq #(
  parameter int PHASE_W    = 3,
  parameter int PIPE_DEPTH = 2,
  localparam int STAT_W    = PHASE_W + 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               done_pin_in,
  input  logic               clk_locked,
  input  logic               imp_matched,
  input  logic               opt_wait_lock,
  input  logic               opt_wait_match,
  input  logic               opt_drive_done,
  input  logic               opt_done_pipe,
  input  logic [PHASE_W-1:0] ph_done,
  input  logic [PHASE_W-1:0] ph_gts,
  input  logic [PHASE_W-1:0] ph_gwe,
  input  logic [PHASE_W-1:0] ph_eos,
  output logic               done_oe,
  output logic               done_out,
  output logic               gts,
  output logic               gwe,
  output logic               eos,
  output logic [STAT_W-1:0]  status
);

  localparam logic [PHASE_W-1:0] LAST = PHASE_W'((1 << PHASE_W) - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  st_t                  st;
  logic [PHASE_W-1:0]   phase_q;
  logic                 released, gts_q, gwe_q, eos_q;
  logic                 pin_s1, lock_q, match_q;
  logic [PIPE_DEPTH-1:0] pin_pipe;

  wire done_seen = opt_done_pipe ? pin_pipe[PIPE_DEPTH-1] : pin_s1;
  wire wait_ok   = (!opt_wait_lock || clk_locked) && (!opt_wait_match || imp_matched);
  wire ev_done   = (phase_q == ph_done);
  wire ev_gts    = (phase_q == ph_gts);
  wire ev_gwe    = (phase_q == ph_gwe);
  wire ev_eos    = (phase_q == ph_eos);
  wire gated     = (ev_done || ev_gts || ev_gwe) && !wait_ok;
  wire pin_hold  = released && !done_seen;
  wire step      = (st == S_RUN) && !gated && !pin_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s1   <= 1'b0;
      lock_q   <= 1'b0;
      match_q  <= 1'b0;
      pin_pipe <= '0;
    end else begin
      pin_s1      <= done_pin_in;
      lock_q      <= clk_locked;
      match_q     <= imp_matched;
      pin_pipe[0] <= pin_s1;
      for (int i = 1; i < PIPE_DEPTH; i++) pin_pipe[i] <= pin_pipe[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      phase_q  <= '0;
      released <= 1'b0;
      gts_q    <= 1'b1;
      gwe_q    <= 1'b0;
      eos_q    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st      <= S_RUN;
          phase_q <= '0;
        end
        S_RUN: if (step) begin
          if (ev_done) released <= 1'b1;
          if (ev_gts)  gts_q    <= 1'b0;
          if (ev_gwe)  gwe_q    <= 1'b1;
          if (ev_eos)  eos_q    <= 1'b1;
          if (phase_q == LAST) st <= S_FIN;
          else phase_q <= phase_q + 1'b1;
        end
        default: st <= S_FIN;
      endcase
    end
  end

  assign done_oe  = !released || opt_drive_done;
  assign done_out = released;
  assign gts      = gts_q;
  assign gwe      = gwe_q;
  assign eos      = eos_q;
  assign status   = {phase_q, match_q, lock_q, eos_q, gwe_q, gts_q, pin_s1, released};

  // R1
  idle_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (gts_q && !gwe_q && !eos_q && !released));

  // R4
  release_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(released) |-> ($past(phase_q) == $past(ph_done)));

  // R5
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && released && !done_seen) |=> ($stable(phase_q) && $stable(gts_q) && $stable(gwe_q)));

  // R7
  gwe_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gwe_q) |-> $past(!opt_wait_lock || clk_locked));

  // R8
  gwe_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gwe_q) |-> $past(!opt_wait_match || imp_matched));

  // R10
  eos_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eos_q |=> eos_q);

endmodule

// File: tb/test_startup_seq.sv
`timescale 1ns/1ps
module test_startup_seq;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pin = 1'b1;
  logic lock = 1'b1, match = 1'b1, wl = 1'b0, wm = 1'b0, drv = 1'b0, pipe = 1'b0;
  logic [2:0] pd = 3'd4, pg = 3'd5, pw = 3'd6, pe = 3'd7;
  logic done_oe, done_out, gts, gwe, eos;
  logic [9:0] status;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  startup_seq i_startup_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .done_pin_in(pin),
    .clk_locked(lock), .imp_matched(match), .opt_wait_lock(wl),
    .opt_wait_match(wm), .opt_drive_done(drv), .opt_done_pipe(pipe),
    .ph_done(pd), .ph_gts(pg), .ph_gwe(pw), .ph_eos(pe),
    .done_oe(done_oe), .done_out(done_out), .gts(gts), .gwe(gwe),
    .eos(eos), .status(status)
  );

  // columns: ph_done, ph_gts, ph_gwe, ph_eos, wait_lock, wait_match, drive_done
  localparam int NV = 6;
  localparam int VEC [NV][7] = '{
    '{4, 5, 6, 7, 0, 0, 0},
    '{0, 0, 0, 0, 0, 0, 0},
    '{2, 1, 3, 5, 0, 0, 0},
    '{7, 7, 7, 0, 0, 0, 0},
    '{4, 5, 6, 7, 1, 1, 0},
    '{3, 6, 2, 7, 0, 0, 1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    edges(2);
    rst_n = 1'b1;
    edges(1);
  endtask

  task automatic kick();
    start = 1'b1;
    edges(1);
    start = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c_rel, c_gts, c_gwe, c_eos;
    do_reset();
    // R1 reset state
    chk(gts == 1 && gwe == 0 && eos == 0, "R1 gts/gwe/eos", {gts, gwe, eos}, 3'b100);
    chk(done_oe == 1 && done_out == 0, "R1 done drive", {done_oe, done_out}, 2'b10);
    edges(5);
    chk(status[9:7] == 0 && gts == 1, "R1 idle without start", status[9:7], 0);

    // R2 R3 R4 R9 table walk
    for (int v = 0; v < NV; v++) begin
      pd = 3'(VEC[v][0]); pg = 3'(VEC[v][1]); pw = 3'(VEC[v][2]); pe = 3'(VEC[v][3]);
      wl = VEC[v][4][0]; wm = VEC[v][5][0]; drv = VEC[v][6][0];
      lock = 1'b1; match = 1'b1; pin = 1'b1; pipe = 1'b0;
      do_reset();
      kick();
      c_rel = -1; c_gts = -1; c_gwe = -1; c_eos = -1;
      for (int k = 1; k <= 14; k++) begin
        edges(1);
        if (c_rel < 0 && done_out) c_rel = k;
        if (c_gts < 0 && !gts) c_gts = k;
        if (c_gwe < 0 && gwe) c_gwe = k;
        if (c_eos < 0 && eos) c_eos = k;
      end
      chk(c_rel == VEC[v][0] + 1, "R3 DONE phase", c_rel, VEC[v][0] + 1);
      chk(c_gts == VEC[v][1] + 1, "R3 GTS phase", c_gts, VEC[v][1] + 1);
      chk(c_gwe == VEC[v][2] + 1, "R2 GWE phase", c_gwe, VEC[v][2] + 1);
      chk(c_eos == VEC[v][3] + 1, "R2 EOS phase", c_eos, VEC[v][3] + 1);
      chk(done_oe == VEC[v][6][0], "R4/R9 done_oe after release", done_oe, VEC[v][6]);
      chk(status[0] == 1, "R4 release status", status[0], 1);
    end

    // R10 sticky after finish, start ignored
    pin = 1'b0;
    kick();
    edges(4);
    chk(eos == 1 && gwe == 1 && gts == 0, "R10 finished outputs hold", {eos, gwe, gts}, 3'b110);

    // R5 DONE line held low
    pd = 4; pg = 5; pw = 6; pe = 7; wl = 0; wm = 0; drv = 0; pipe = 0; pin = 1'b0;
    do_reset();
    kick();
    edges(20);
    chk(status[9:7] == 5 && gts == 1, "R5 held at phase 5", status[9:7], 5);
    chk(done_oe == 0 && status[0] == 1 && status[1] == 0, "R4 released while line low", status[1:0], 2'b01);
    pin = 1'b1;
    edges(1);
    chk(gts == 1, "R5 one edge after line high", gts, 1);
    chk(status[1] == 1, "R11 sampled DONE bit", status[1], 1);
    edges(1);
    chk(gts == 0, "R5 two edges after line high", gts, 0);

    // R6 pipeline option
    pin = 1'b0; pipe = 1'b1;
    do_reset();
    kick();
    edges(20);
    pin = 1'b1;
    edges(3);
    chk(gts == 1, "R6 three edges after line high", gts, 1);
    edges(1);
    chk(gts == 0, "R6 four edges after line high", gts, 0);

    // R7 clock-lock wait
    pin = 1'b1; pipe = 0; wl = 1; lock = 1'b0;
    do_reset();
    kick();
    edges(20);
    chk(status[9:7] == 4 && done_oe == 1, "R7 held at phase 4", status[9:7], 4);
    chk(status[5] == 0, "R11 lock bit low", status[5], 0);
    lock = 1'b1;
    edges(1);
    chk(done_oe == 0, "R7 release on lock", done_oe, 0);
    chk(status[5] == 1, "R11 lock bit high", status[5], 1);

    // R8 impedance-match wait
    wl = 0; wm = 1; match = 1'b0; pd = 6; pg = 2; pw = 3; pe = 7;
    do_reset();
    kick();
    edges(20);
    chk(status[9:7] == 2 && gts == 1, "R8 held at phase 2", status[9:7], 2);
    chk(status[6] == 0, "R11 match bit low", status[6], 0);
    match = 1'b1;
    edges(1);
    chk(gts == 0, "R8 GTS on match", gts, 0);
    chk(status[6] == 1, "R11 match bit high", status[6], 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule